// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous internal request port and an external byte-wide asynchronous static RAM of 512K locations. A requester presents one read or write per accepted handshake; the controller then sequences the RAM's chip selects, write strobe and read strobe over several clock cycles so that every edge-relative timing limit of the memory is met. Read data comes back on a separate response port with a one-cycle valid pulse.

All memory timing limits are entered as nanosecond parameters together with the clock period, and the controller derives its cycle counts by rounding up. The data bus is bidirectional at the pad, so the controller exposes it as a driven value, a drive enable and a sampled input; pad buffers live outside this block. Writes are framed by the write strobe with both chip selects held active around it, and the controller only turns its bus driver on after the memory has had time to release the bus, and never while the read strobe is active.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1, mem_dout_en=0, rsp_valid=0 and req_ready=1.
- R2: An accepted write first spends one cycle with both chip selects active and mem_wr_n high, then holds mem_wr_n low for exactly 5 cycles (default parameters) with both selects active and mem_addr unchanged, then returns all strobes to inactive.
- R3: mem_dout_en is high only while mem_wr_n is low; it rises in the third cycle of the write strobe (2 cycles after mem_wr_n falls), stays high through the last strobe cycle (3 cycles), and mem_dout carries the accepted write data, which the memory then holds.
- R4: mem_rd_n is high in every cycle in which mem_dout_en is high.
- R5: An accepted read holds both selects active, mem_wr_n high and mem_rd_n low for exactly 6 cycles; mem_din is sampled on the edge that ends the sixth cycle and returned on rsp_rdata with rsp_valid high for a single cycle.
- R6: req_ready is high only when no cycle is in progress; a request presented while req_ready is low is not taken and neither its address nor its data reaches the memory.
- R7: A read accepted in the first idle cycle after a write leaves 3 cycles with mem_wr_n and mem_rd_n both high between the rise of mem_wr_n and the fall of mem_rd_n (recovery, idle, turnaround).
- R8: req_ready stays low for 7 cycles per write and 6 cycles per read started from idle with no preceding write pending.
- R9: rsp_rdata keeps the last read value until another read completes; writes leave it unchanged.
- R10: mem_addr carries the full 19-bit request address during the strobes of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 19 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output-enable strobe |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 8 | Data sampled from the memory bus |

## Verification
The hardest case to reach is a read that enters the controller in the very first idle cycle after a write, because only then does the turnaround cycle appear and only then could the read strobe collide with a bus still settling from the write. The bench gets there by presenting the read request while the write is still busy, so it is held until the controller returns to idle and is accepted on that first cycle; a garbage request is also held during a busy write to show it is not taken. The memory model returns a poison byte until the read strobe has been active long enough, so an early sample is visible at the response port.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WRECOV = 3'd3,
        ST_TURN   = 3'd4,
        ST_READ   = 3'd5
    } ctrl_state_e;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        if (ns <= 0) return 0;
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PULSE_CYC   = 5,
    parameter int DRIVE_DELAY = 2,
    parameter int RECOV_CYC   = 1,
    parameter int READ_CYC    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              load_wdata,
    output logic              capture,
    output logic              drive_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n
);

    localparam int CNT_MAX = imax(imax(PULSE_CYC, RECOV_CYC), READ_CYC);
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              sel_n;
        logic              sel;
        logic              wr_n;
        logic              rd_n;
        logic              drive;
        logic              after_wr;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st:       ST_IDLE,
        cnt:      '0,
        addr:     '0,
        sel_n:    1'b1,
        sel:      1'b0,
        wr_n:     1'b1,
        rd_n:     1'b1,
        drive:    1'b0,
        after_wr: 1'b0
    };

    fsm_t q, d;
    logic accept;

    always_comb begin
        d          = q;
        req_ready  = (q.st == ST_IDLE);
        accept     = req_valid && req_ready;
        load_wdata = accept && req_write;
        capture    = (q.st == ST_READ) && (q.cnt == CNT_W'(READ_CYC - 1));

        case (q.st)
            ST_IDLE: begin
                d.after_wr = 1'b0;
                if (accept) begin
                    d.addr = req_addr;
                    d.cnt  = '0;
                    if (req_write) begin
                        d.st    = ST_WSETUP;
                        d.sel_n = 1'b0;
                        d.sel   = 1'b1;
                    end else if (q.after_wr) begin
                        d.st = ST_TURN;
                    end else begin
                        d.st    = ST_READ;
                        d.sel_n = 1'b0;
                        d.sel   = 1'b1;
                        d.rd_n  = 1'b0;
                    end
                end
            end
            ST_WSETUP: begin
                d.st    = ST_WPULSE;
                d.wr_n  = 1'b0;
                d.cnt   = '0;
                d.drive = (DRIVE_DELAY == 0);
            end
            ST_WPULSE: begin
                if (q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                    d.st    = ST_WRECOV;
                    d.wr_n  = 1'b1;
                    d.sel_n = 1'b1;
                    d.sel   = 1'b0;
                    d.drive = 1'b0;
                    d.cnt   = '0;
                end else begin
                    d.cnt   = q.cnt + 1'b1;
                    d.drive = (int'(q.cnt) + 1 >= DRIVE_DELAY);
                end
            end
            ST_WRECOV: begin
                if (q.cnt == CNT_W'(RECOV_CYC - 1)) begin
                    d.st       = ST_IDLE;
                    d.cnt      = '0;
                    d.after_wr = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TURN: begin
                d.st    = ST_READ;
                d.sel_n = 1'b0;
                d.sel   = 1'b1;
                d.rd_n  = 1'b0;
                d.cnt   = '0;
            end
            ST_READ: begin
                if (capture) begin
                    d.st    = ST_IDLE;
                    d.sel_n = 1'b1;
                    d.sel   = 1'b0;
                    d.rd_n  = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign mem_addr  = q.addr;
    assign mem_sel_n = q.sel_n;
    assign mem_sel   = q.sel;
    assign mem_wr_n  = q.wr_n;
    assign mem_rd_n  = q.rd_n;
    assign drive_en  = q.drive;

    // R2: the write strobe only falls inside an active chip-select window
    p_wr_in_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.wr_n |-> (!q.sel_n && q.sel));

    // R2: address frozen while the write strobe is low
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.wr_n |-> $stable(q.addr));

    // R5: read strobe never overlaps the write strobe
    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd_n |-> q.wr_n);

    // R6: no handshake while the write strobe is active
    p_busy_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.wr_n |-> !req_ready);

    // R7: the read strobe falls only after three cycles of write strobe high
    p_rd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rd_n) |-> ($past(q.wr_n) && $past(q.wr_n, 2) && $past(q.wr_n, 3)));

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drive_en,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_din,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } dp_t;

    dp_t q, d;

    always_comb begin
        d      = q;
        d.done = capture;
        if (load_wdata) d.wdata = req_wdata;
        if (capture)    d.rdata = mem_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_dout    = q.wdata;
    assign mem_dout_en = drive_en;
    assign rsp_rdata   = q.rdata;
    assign rsp_valid   = q.done;

    // R5: response valid lasts a single cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R9: read data changes only on the cycle a response is presented
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.rdata));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 19,
    parameter int DATA_W          = 8,
    parameter int CLK_NS          = 10,
    parameter int WR_CYCLE_NS     = 55,
    parameter int WR_STROBE_NS    = 45,
    parameter int ADDR_TO_END_NS  = 50,
    parameter int DATA_SETUP_NS   = 25,
    parameter int RELEASE_NS      = 20,
    parameter int RD_CYCLE_NS     = 55,
    parameter int ADDR_ACCESS_NS  = 55,
    parameter int RD_EN_ACCESS_NS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int WC_C  = ns_to_cycles(WR_CYCLE_NS, CLK_NS);
    localparam int WP_C  = ns_to_cycles(WR_STROBE_NS, CLK_NS);
    localparam int AW_C  = ns_to_cycles(ADDR_TO_END_NS, CLK_NS);
    localparam int DS_C  = ns_to_cycles(DATA_SETUP_NS, CLK_NS);
    localparam int REL_C = ns_to_cycles(RELEASE_NS, CLK_NS);
    localparam int RC_C  = ns_to_cycles(RD_CYCLE_NS, CLK_NS);
    localparam int AA_C  = ns_to_cycles(ADDR_ACCESS_NS, CLK_NS);
    localparam int OE_C  = ns_to_cycles(RD_EN_ACCESS_NS, CLK_NS);

    // Strobe must cover its own minimum, address-to-end and release plus data setup.
    localparam int PULSE_C = imax(1, imax(imax(WP_C, AW_C - 1), REL_C + imax(DS_C, 1)));
    // Setup cycle + strobe + recovery must cover the full write cycle.
    localparam int RECOV_C = imax(1, WC_C - PULSE_C - 1);
    localparam int READ_C  = imax(1, imax(imax(RC_C, AA_C), OE_C));

    logic load_wdata;
    logic capture;
    logic drive_en;

    sram_strobe_fsm #(
        .ADDR_W      (ADDR_W),
        .PULSE_CYC   (PULSE_C),
        .DRIVE_DELAY (REL_C),
        .RECOV_CYC   (RECOV_C),
        .READ_CYC    (READ_C)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .load_wdata (load_wdata),
        .capture    (capture),
        .drive_en   (drive_en),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n)
    );

    sram_dq_path #(
        .DATA_W (DATA_W)
    ) i_dq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_wdata  (load_wdata),
        .req_wdata   (req_wdata),
        .drive_en    (drive_en),
        .capture     (capture),
        .mem_din     (mem_din),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .rsp_rdata   (rsp_rdata),
        .rsp_valid   (rsp_valid)
    );

    // R4: never drive the bus while the memory may drive it
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_rd_n);

    // R3: drive only inside the write strobe
    p_drive_in_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> !mem_wr_n);

    // R3: the driver turns on only after the strobe has already been low
    p_drive_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> $past(!mem_wr_n));

    // R5: a response only appears once the read strobe has been released
    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_rd_n && $past(!mem_rd_n)));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_wr_n, mem_rd_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    sram_async_ctrl i_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .mem_addr    (mem_addr),
        .mem_sel_n   (mem_sel_n),
        .mem_sel     (mem_sel),
        .mem_wr_n    (mem_wr_n),
        .mem_rd_n    (mem_rd_n),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .mem_din     (mem_din)
    );

    // Memory model: byte array on the low address bits, poison until access time.
    logic [DW-1:0] mem     [256];
    logic [DW-1:0] ref_mem [256];
    logic [DW-1:0] wbuf;
    int            rd_age;
    logic          selected;

    assign selected = !mem_sel_n && mem_sel;
    assign mem_din  = (selected && mem_wr_n && !mem_rd_n && rd_age >= 5) ? mem[mem_addr[7:0]] : 8'hA5;

    always @(posedge clk) begin
        if (selected && mem_wr_n && !mem_rd_n) rd_age <= rd_age + 1;
        else                                   rd_age <= 0;
    end

    // Scoreboard queues
    logic [DW-1:0] exp_q   [$];
    logic [AW-1:0] raddr_q [$];
    logic [AW-1:0] waddr_q [$];

    // Monitor
    int   we_run = 0, drv_run = 0, oe_run = 0, busy_run = 0, last_busy = 0;
    int   gap = 0, last_gap = 0;
    bit   prev_we = 1, prev_oe = 1, prev_ready = 1, prev_done = 0, we_during_oe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_wr_n) begin
                chk(selected, "R2 selects during strobe", int'(selected), 1);
                we_run++;
                if (mem_dout_en) begin
                    if (drv_run == 0) chk(we_run == 3, "R3 drive start", we_run, 3);
                    drv_run++;
                    wbuf = mem_dout;
                end
            end else begin
                if (mem_dout_en) chk(0, "R3 drive outside strobe", 1, 0);
            end
            if (mem_dout_en) chk(mem_rd_n == 1'b1, "R4 read strobe while driving", int'(mem_rd_n), 1);

            if (!prev_we && mem_wr_n) begin
                chk(we_run == 5, "R2 strobe width", we_run, 5);
                chk(drv_run == 3, "R3 drive width", drv_run, 3);
                chk(!selected, "R2 selects released", int'(selected), 0);
                if (waddr_q.size() > 0) begin
                    logic [AW-1:0] ea;
                    ea = waddr_q.pop_front();
                    chk(mem_addr == ea, "R10 write address", int'(mem_addr), int'(ea));
                end
                mem[mem_addr[7:0]] = wbuf;
                we_run  = 0;
                drv_run = 0;
                gap     = 1;
            end else if (prev_oe && !mem_rd_n) begin
                last_gap = gap;
                gap      = 0;
            end else if (mem_rd_n) begin
                gap++;
            end

            if (!mem_rd_n) begin
                oe_run++;
                if (!mem_wr_n || !selected) we_during_oe = 1;
            end
            if (!prev_oe && mem_rd_n) begin
                chk(oe_run == 6, "R5 read strobe width", oe_run, 6);
                chk(!we_during_oe, "R5 write strobe high during read", int'(we_during_oe), 0);
                if (raddr_q.size() > 0) begin
                    logic [AW-1:0] ra;
                    ra = raddr_q.pop_front();
                    chk(mem_addr == ra, "R10 read address", int'(mem_addr), int'(ra));
                end
                oe_run       = 0;
                we_during_oe = 0;
            end

            if (!req_ready) busy_run++;
            if (!prev_ready && req_ready) begin
                last_busy = busy_run;
                busy_run  = 0;
            end

            if (rsp_valid) begin
                chk(!prev_done, "R5 single-cycle response", int'(prev_done), 0);
                if (exp_q.size() == 0) chk(0, "R5 unexpected response", int'(rsp_rdata), 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R5 read data", int'(rsp_rdata), int'(e));
                end
            end

            prev_we    = mem_wr_n;
            prev_oe    = mem_rd_n;
            prev_ready = req_ready;
            prev_done  = rsp_valid;
        end
    end

    // Driver tasks
    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] dat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = dat;
        while (!req_ready) @(negedge clk);
        if (wr) begin
            ref_mem[a[7:0]] = dat;
            waddr_q.push_back(a);
        end else begin
            exp_q.push_back(ref_mem[a[7:0]]);
            raddr_q.push_back(a);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'hC3;
            ref_mem[i] = 8'hC3;
        end
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);

        // R1 reset levels
        chk(mem_sel_n == 1'b1, "R1 sel_n", int'(mem_sel_n), 1);
        chk(mem_sel == 1'b0, "R1 sel", int'(mem_sel), 0);
        chk(mem_wr_n == 1'b1, "R1 wr_n", int'(mem_wr_n), 1);
        chk(mem_rd_n == 1'b1, "R1 rd_n", int'(mem_rd_n), 1);
        chk(mem_dout_en == 1'b0, "R1 dout_en", int'(mem_dout_en), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        rst_n = 1'b1;

        // R7: read queued behind a write, full-width address (R10)
        send(1'b1, 19'h7FF12, 8'h3C);
        send(1'b0, 19'h7FF12, 8'h00);
        wait_idle();
        chk(last_gap == 3, "R7 turnaround gap", last_gap, 3);

        // R8: write from idle, then read from idle
        send(1'b1, 19'h00040, 8'h00);
        wait_idle();
        chk(last_busy == 7, "R8 write busy", last_busy, 7);
        repeat (3) @(negedge clk);
        send(1'b0, 19'h00040, 8'h00);
        wait_idle();
        chk(last_busy == 6, "R8 read busy", last_busy, 6);

        // Read after read
        send(1'b0, 19'h7FF12, 8'h00);
        send(1'b0, 19'h00040, 8'h00);
        wait_idle();

        // R6: a request held while busy must not be taken
        send(1'b1, 19'h00021, 8'h77);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 19'h00030;
        req_wdata = 8'hEE;
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        send(1'b0, 19'h00030, 8'h00);
        send(1'b0, 19'h00021, 8'h00);
        wait_idle();
        chk(mem[8'h30] == 8'hC3, "R6 ignored write left memory", int'(mem[8'h30]), 8'hC3);

        // Several data patterns back to back
        send(1'b1, 19'h00001, 8'hFF);
        send(1'b1, 19'h00002, 8'h5A);
        send(1'b1, 19'h00003, 8'h81);
        send(1'b0, 19'h00003, 8'h00);
        send(1'b0, 19'h00001, 8'h00);
        send(1'b0, 19'h00002, 8'h00);
        wait_idle();
        chk(mem[8'h02] == 8'h5A, "R3 stored data", int'(mem[8'h02]), 8'h5A);

        // R9: a write leaves the last read data unchanged
        send(1'b1, 19'h00004, 8'h11);
        wait_idle();
        chk(rsp_rdata == 8'h5A, "R9 read data held", int'(rsp_rdata), 8'h5A);
        chk(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule